// File: doc/BRIEF.md
# Masked-Write DMA Channel Control Register

This block holds the control and status word of a single descriptor-driven DMA channel. Software writes the block with 32-bit words. The upper half of each word selects which bits of the 16-bit status word change, and the lower half supplies their new values. Software can therefore start, pause or stop the channel, or flip a general-purpose flag, in one write and without reading the register first. A read returns the 16-bit status word, combinationally, from the held state.

The channel engine talks to the block through a few signals. It pulses inputs that raise the halted and dead flags. It reports whether it is moving data and whether it sits at a descriptor boundary. It receives the run and pause levels, plus a one-cycle stop request whenever run drops. Software can only clear halted and dead. Only the engine can set them. The active and paused flags are never written directly. They follow the engine, gated by run and pause.

Top module: `dma_chan_ctrl`

## Requirements
- R1: On a write, run (bit 15, select 31), pause (bit 14, select 30) and the general flags G3..G0 (bits 3..0, selects 19..16) each take the lower-half value bit when their select bit is 1. They keep their value when the select bit is 0 or when there is no write. The new value shows on `rd_data` one cycle after the write.
- R2: Halted (bit 13, select 29) and dead (bit 12, select 28) clear on a write that has the select bit at 1 and the value bit at 0. A write with the value bit at 1 leaves them unchanged.
- R3: A pulse on `eng_set_halt` or `eng_set_dead` sets halted or dead one cycle later. The pulse wins over a software clear in the same cycle.
- R4: Active (bit 11) is updated on every cycle. It becomes `eng_active` when the run and pause values taking effect on that edge are 1 and 0. Otherwise it becomes 0, so clearing run clears active on the same edge. Select bit 27 has no effect.
- R5: Paused (bit 10) becomes 1 one cycle after a cycle in which the pause value taking effect is 1 and `eng_boundary` is 1. Otherwise it becomes 0. Select bit 26 has no effect.
- R6: `stop_req` is 1 for exactly the one cycle in which run first reads 0 after reading 1.
- R7: The single write 0xF00F0000 clears run, pause, halted, dead and G3..G0 together.
- R8: Reset clears every status bit and `stop_req`. Bits 9..4 of `rd_data` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Select bits in [31:16], value bits in [15:0] |
| rd_data | output | 16 | Status word |
| eng_set_halt | input | 1 | Engine pulse that sets halted |
| eng_set_dead | input | 1 | Engine pulse that sets dead |
| eng_active | input | 1 | Engine is moving data |
| eng_boundary | input | 1 | Engine is at a descriptor boundary |
| run_o | output | 1 | Run level to the engine |
| pause_o | output | 1 | Pause level to the engine |
| stop_req | output | 1 | One-cycle stop request to the engine |

## Verification
The bench targets five corner cases:

- **Software trying to set halted or dead.** A design that honoured the value bit would let software fake an engine fault.
- **A clear that lands in the same cycle as an engine set pulse.** Letting software win would lose a fault report.
- **The clear-all word.** It must drop every flag at once, so a slip in decoding any one select bit would leave a stale flag behind.
- **Clearing run while the engine is active.** Active must fall on the same edge as run, and the stop request must appear exactly once. An off-by-one in the gating shows up as an extra or missing cycle.
- **Random select/value words.** These cover the rest and expose any select bit that leaks into a neighbour or any reserved bit that reads non-zero.

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int SW_W = 16,
  parameter int GP_N = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2*SW_W-1:0] wr_data,
  output logic [SW_W-1:0] rd_data,
  input  logic            eng_set_halt,
  input  logic            eng_set_dead,
  input  logic            eng_active,
  input  logic            eng_boundary,
  output logic            run_o,
  output logic            pause_o,
  output logic            stop_req
);
  localparam int B_RUN = SW_W - 1;
  localparam int B_PAU = SW_W - 2;
  localparam int B_HLT = SW_W - 3;
  localparam int B_DED = SW_W - 4;
  localparam int B_ACT = SW_W - 5;
  localparam int B_PZD = SW_W - 6;
  localparam int RSV_W = B_PZD - GP_N;

  logic [SW_W-1:0] sel, val;
  logic run_q, pau_q, hlt_q, ded_q, act_q, pzd_q, stop_q;
  logic run_n, pau_n, hlt_n, ded_n;
  logic [GP_N-1:0] gp_q, gp_n;

  assign sel = wr_en ? wr_data[2*SW_W-1:SW_W] : '0;
  assign val = wr_data[SW_W-1:0];

  assign run_n = sel[B_RUN] ? val[B_RUN] : run_q;
  assign pau_n = sel[B_PAU] ? val[B_PAU] : pau_q;
  assign hlt_n = eng_set_halt | (hlt_q & ~(sel[B_HLT] & ~val[B_HLT]));
  assign ded_n = eng_set_dead | (ded_q & ~(sel[B_DED] & ~val[B_DED]));
  assign gp_n  = (gp_q & ~sel[GP_N-1:0]) | (val[GP_N-1:0] & sel[GP_N-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pau_q  <= 1'b0;
      hlt_q  <= 1'b0;
      ded_q  <= 1'b0;
      act_q  <= 1'b0;
      pzd_q  <= 1'b0;
      stop_q <= 1'b0;
      gp_q   <= '0;
    end else begin
      run_q  <= run_n;
      pau_q  <= pau_n;
      hlt_q  <= hlt_n;
      ded_q  <= ded_n;
      act_q  <= run_n & ~pau_n & eng_active;
      pzd_q  <= pau_n & eng_boundary;
      stop_q <= run_q & ~run_n;
      gp_q   <= gp_n;
    end
  end

  assign rd_data  = {run_q, pau_q, hlt_q, ded_q, act_q, pzd_q, {RSV_W{1'b0}}, gp_q};
  assign run_o    = run_q;
  assign pause_o  = pau_q;
  assign stop_req = stop_q;
endmodule

module dma_chan_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [15:0] rd_data,
  input logic        eng_set_halt,
  input logic        eng_set_dead,
  input logic        stop_req
);
  p_sel_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[31] |=> rd_data[15] == $past(wr_data[15]));
  p_hold_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[31]) |=> $stable(rd_data[15]));
  p_hold_gp0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[16]) |=> $stable(rd_data[0]));
  p_no_sw_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[13] && !eng_set_halt |=> !rd_data[13]);
  p_no_sw_dead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[12] && !eng_set_dead |=> !rd_data[12]);
  p_hw_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_set_halt |=> rd_data[13]);
  p_hw_dead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_set_dead |=> rd_data[12]);
  p_act_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[11] |-> rd_data[15] && !rd_data[14]);
  p_pzd_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[10] |-> rd_data[14]);
  p_stop_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[15]) |-> stop_req);
  p_stop_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !stop_req);
  p_stop_run_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> !rd_data[15]);
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .eng_set_halt(eng_set_halt),
  .eng_set_dead(eng_set_dead), .stop_req(stop_req)
);

// File: tb/dma_chan_ctrl_tb.sv
module dma_chan_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        eng_set_halt = 1'b0, eng_set_dead = 1'b0;
  logic        eng_active = 1'b0, eng_boundary = 1'b0;
  logic        run_o, pause_o, stop_req;

  int checks = 0;
  int errors = 0;
  logic [15:0] model = '0;
  logic        stop_exp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .eng_set_halt(eng_set_halt),
    .eng_set_dead(eng_set_dead), .eng_active(eng_active),
    .eng_boundary(eng_boundary), .run_o(run_o), .pause_o(pause_o),
    .stop_req(stop_req)
  );

  function automatic logic [15:0] next_word(
    input logic [15:0] old, input logic we, input logic [31:0] d,
    input logic sh, input logic sd, input logic ea, input logic eb);
    logic [15:0] m, v, n;
    m = we ? d[31:16] : 16'h0;
    v = d[15:0];
    n = 16'h0;
    n[15] = m[15] ? v[15] : old[15];
    n[14] = m[14] ? v[14] : old[14];
    n[3:0] = (old[3:0] & ~m[3:0]) | (v[3:0] & m[3:0]);
    n[13] = sh ? 1'b1 : ((m[13] && !v[13]) ? 1'b0 : old[13]);
    n[12] = sd ? 1'b1 : ((m[12] && !v[12]) ? 1'b0 : old[12]);
    n[11] = n[15] & ~n[14] & ea;
    n[10] = n[14] & eb;
    return n;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare();
    check(rd_data[15:14] == model[15:14] && rd_data[3:0] == model[3:0], "R1 control bits", rd_data, model);
    check(rd_data[13:12] == model[13:12], "R2 R3 halted/dead", rd_data, model);
    check(rd_data[11] == model[11], "R4 active", rd_data, model);
    check(rd_data[10] == model[10], "R5 paused", rd_data, model);
    check(stop_req == stop_exp, "R6 stop_req", stop_req, stop_exp);
    check(rd_data[9:4] == 6'h0, "R8 reserved bits", rd_data, model);
    check(run_o == model[15] && pause_o == model[14], "R1 engine levels", {run_o, pause_o}, model[15:14]);
  endtask

  task automatic step(input logic we, input logic [31:0] d, input logic sh, input logic sd,
                      input logic ea, input logic eb);
    logic [15:0] n;
    wr_en = we; wr_data = d; eng_set_halt = sh; eng_set_dead = sd;
    eng_active = ea; eng_boundary = eb;
    n = next_word(model, we, d, sh, sd, ea, eb);
    stop_exp = model[15] & ~n[15];
    model = n;
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(rd_data == 16'h0 && stop_req == 1'b0, "R8 reset state", {stop_req, rd_data}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    // R1: start run and set G2/G0
    step(1, 32'h8005_8005, 0, 0, 1, 0);
    // R4: active follows engine while running
    step(0, 32'h0, 0, 0, 1, 0);
    // R2: software attempt to set halted/dead is ignored
    step(1, 32'h3000_3000, 0, 0, 1, 0);
    check(rd_data[13:12] == 2'b00, "R2 sw set ignored", rd_data, 16'h0);
    // R3: engine sets halted and dead
    step(0, 32'h0, 1, 1, 1, 0);
    // R3: engine set wins over same-cycle clear
    step(1, 32'h3000_0000, 1, 0, 1, 0);
    check(rd_data[13:12] == 2'b10, "R3 set beats clear", rd_data[13:12], 2'b10);
    // R5: pause at a boundary
    step(1, 32'h4000_4000, 0, 0, 1, 1);
    check(rd_data[10] == 1'b1 && rd_data[11] == 1'b0, "R5 paused at boundary", rd_data, 16'h0400);
    step(1, 32'h4000_0000, 0, 0, 1, 1);
    // R4 R6: clearing run drops active and pulses stop_req once
    step(1, 32'h8000_0000, 0, 0, 1, 0);
    check(stop_req == 1'b1 && rd_data[11] == 1'b0, "R6 stop pulse", {stop_req, rd_data[11]}, 2'b10);
    step(0, 32'h0, 0, 0, 1, 0);
    check(stop_req == 1'b0, "R6 stop single cycle", stop_req, 1'b0);
    // R4: select 27 / value 11 has no direct effect
    step(1, 32'h0800_0800, 0, 0, 0, 0);
    // R7: clear-all after setting everything
    step(1, 32'hC00F_C00F, 1, 1, 1, 1);
    step(1, 32'hF00F_0000, 0, 0, 1, 1);
    check(rd_data == 16'h0, "R7 clear all", rd_data, 16'h0);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] d;
      d = $urandom;
      step(($urandom % 4) != 0, d, ($urandom % 16) == 0, ($urandom % 16) == 0,
           $urandom % 2, $urandom % 2);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule